// File: doc/BRIEF.md
# 40-bit DSP Barrel Shifter

This block shifts and rotates a 40-bit operand for a fixed-point DSP datapath. It does so in a single combinational pass. The operand is either a full 40-bit accumulator or a 32-bit word that the block widens to 40 bits itself. The shift amount is a 6-bit signed two's-complement number: its sign sets the direction and its magnitude sets the distance.

The amount comes from one of three places, chosen per operation: an immediate field, a barrel-shift control register, or a product-shift control register. The two control registers are the only state in the block. Each is loaded through its own write-enable and write-data port.

An operation code chooses one of four functions: arithmetic shift, logical shift, 32-bit rotate, or rotate through an external test bit. Every pure shift returns, as the new test bit, the last bit that left the operand. The datapath around the block decides whether to keep that bit in its condition flags.

Top module: `dsp_barrel_shifter`

## Requirements
- R1: After reset both control registers hold 0, so any operation whose amount comes from either register returns the widened operand unchanged and returns the test bit unchanged.
- R2: A control register takes its write data at the clock edge on which its write enable is high. Operations take the new value from the next cycle on; before that edge they use the old value. A write to one register leaves the other unchanged.
- R3: `amt_src` selects the amount as follows. 2'b00 selects the immediate, 2'b01 the barrel-shift register, and 2'b10 the product-shift register. 2'b11 selects an amount of zero.
- R4: An amount of zero passes the widened 40-bit operand to `result` unchanged, and `tst_out` equals `tst_in`, for every operation code.
- R5: Arithmetic shift (op 2'b00) acts on all 40 bits. A left shift fills the low bits with 0. A right shift fills the high bits with copies of bit 39. `tst_out` is the last bit shifted out.
- R6: Logical shift (op 2'b01) acts on bits 31:0 only. Zeros enter from the vacated side, `result[39:32]` is 0, and `tst_out` is the last bit shifted out. A right shift by 32 gives 0 with `tst_out` equal to the old bit 31.
- R7: Rotate (op 2'b10) with a positive amount rotates bits 31:0 left and clears `result[39:32]`. `tst_out` equals `tst_in`.
- R8: A rotate with a negative amount turns bits 31:0 right only when the amount comes from the barrel-shift register. From any other source it passes the widened operand through unchanged. `tst_out` equals `tst_in` in both cases.
- R9: Rotate through the test bit (op 2'b11) with a positive amount rotates the 33-bit ring {test bit, bits 31:0} left. The test bit enters at bit 0, the old bit 31 becomes `tst_out`, and `result[39:32]` is 0. A negative amount passes the widened operand and the test bit through unchanged.
- R10: When `opnd_is_acc` is high the operand is `opnd_acc`. Otherwise it is `opnd_word`, sign-extended to 40 bits for op 2'b00 and zero-extended for every other op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control registers |
| rst_n | input | 1 | Active-low reset, clears both control registers |
| bsc_we | input | 1 | Load enable of the barrel-shift control register |
| bsc_wdata | input | 6 | Signed value for the barrel-shift control register |
| psc_we | input | 1 | Load enable of the product-shift control register |
| psc_wdata | input | 6 | Signed value for the product-shift control register |
| amt_src | input | 2 | Amount source: 00 immediate, 01 barrel-shift reg, 10 product-shift reg, 11 zero |
| imm_amt | input | 6 | Signed immediate shift amount |
| op | input | 2 | 00 arithmetic, 01 logical, 10 rotate, 11 rotate through test bit |
| opnd_is_acc | input | 1 | 1 selects the 40-bit accumulator operand, 0 the 32-bit word |
| opnd_acc | input | 40 | Accumulator operand |
| opnd_word | input | 32 | 32-bit operand |
| tst_in | input | 1 | Current test bit |
| result | output | 40 | Shifted or rotated value |
| tst_out | output | 1 | Updated test bit |

## Verification
A register write and a shift that reads the same register can fall in the same cycle. The bench provokes this by raising `bsc_we` or `psc_we` with a new value while a shift already selects that register. It checks the result once before the clock edge, where the old amount must apply, and once after it, where the new amount must apply.

The zero-amount pass-through and the source-dependent refusal of a right rotate can also meet. Sweeping every signed amount from every source for every operation covers both.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int DBS_ACC_W  = 40;
    localparam int DBS_DATA_W = 32;
    localparam int DBS_AMT_W  = 6;

    typedef enum logic [1:0] {
        OP_ARITH = 2'b00,
        OP_LOGIC = 2'b01,
        OP_ROT   = 2'b10,
        OP_RTT   = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'b00,
        SRC_BSC  = 2'b01,
        SRC_PSC  = 2'b10,
        SRC_NONE = 2'b11
    } amt_src_e;

    typedef struct packed {
        logic [DBS_AMT_W-1:0] bsc;
        logic [DBS_AMT_W-1:0] psc;
    } shift_ctrl_t;
endpackage

// File: rtl/dbs_amt_sel.sv
module dbs_amt_sel
    import dbs_pkg::*;
#(
    parameter int AMT_W = DBS_AMT_W
) (
    input  logic [1:0]       amt_src,
    input  logic [AMT_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] bsc_amt,
    input  logic [AMT_W-1:0] psc_amt,
    output logic [AMT_W-1:0] mag,
    output logic             go_left,
    output logic             is_zero,
    output logic             from_bsc
);
    logic [AMT_W-1:0] raw;

    always_comb begin
        unique case (amt_src_e'(amt_src))
            SRC_IMM: raw = imm_amt;
            SRC_BSC: raw = bsc_amt;
            SRC_PSC: raw = psc_amt;
            default: raw = '0;
        endcase
        go_left  = ~raw[AMT_W-1];
        mag      = raw[AMT_W-1] ? (~raw + 1'b1) : raw;
        is_zero  = (raw == '0);
        from_bsc = (amt_src == SRC_BSC);
    end
endmodule

// File: rtl/dbs_shift_core.sv
module dbs_shift_core
    import dbs_pkg::*;
#(
    parameter int ACC_W  = DBS_ACC_W,
    parameter int DATA_W = DBS_DATA_W,
    parameter int AMT_W  = DBS_AMT_W
) (
    input  logic [1:0]        op,
    input  logic [AMT_W-1:0]  mag,
    input  logic              go_left,
    input  logic              is_zero,
    input  logic              from_bsc,
    input  logic              opnd_is_acc,
    input  logic [ACC_W-1:0]  opnd_acc,
    input  logic [DATA_W-1:0] opnd_word,
    input  logic              tst_in,
    output logic [ACC_W-1:0]  result,
    output logic              tst_out
);
    localparam int EXT_W  = ACC_W - DATA_W;
    localparam int RING_W = DATA_W + 1;
    localparam int SHW    = AMT_W + 1;
    localparam logic [SHW-1:0] DW_S = SHW'(DATA_W);
    localparam logic [SHW-1:0] RW_S = SHW'(RING_W);

    logic [ACC_W-1:0]    ext, ext_sh, ext_pre;
    logic [DATA_W-1:0]   v, w_sh, w_pre;
    logic [2*DATA_W-1:0] dbl;
    logic [2*RING_W-1:0] rdbl;
    logic [SHW-1:0]      n, nm1;

    always_comb begin
        n   = {1'b0, mag};
        nm1 = n - 1'b1;
        if (opnd_is_acc)
            ext = opnd_acc;
        else if (op == OP_ARITH)
            ext = {{EXT_W{opnd_word[DATA_W-1]}}, opnd_word};
        else
            ext = {{EXT_W{1'b0}}, opnd_word};
        v       = ext[DATA_W-1:0];
        ext_sh  = '0;
        ext_pre = '0;
        w_sh    = '0;
        w_pre   = '0;
        dbl     = {v, v};
        rdbl    = {tst_in, v, tst_in, v};
        result  = ext;
        tst_out = tst_in;
        if (!is_zero) begin
            unique case (shift_op_e'(op))
                OP_ARITH: begin
                    if (go_left) begin
                        ext_sh  = ext << n;
                        ext_pre = ext << nm1;
                        tst_out = ext_pre[ACC_W-1];
                    end else begin
                        ext_sh  = $signed(ext) >>> n;
                        ext_pre = ext >> nm1;
                        tst_out = ext_pre[0];
                    end
                    result = ext_sh;
                end
                OP_LOGIC: begin
                    if (go_left) begin
                        w_sh    = v << n;
                        w_pre   = v << nm1;
                        tst_out = w_pre[DATA_W-1];
                    end else begin
                        w_sh    = v >> n;
                        w_pre   = v >> nm1;
                        tst_out = w_pre[0];
                    end
                    result = {{EXT_W{1'b0}}, w_sh};
                end
                OP_ROT: begin
                    if (go_left) begin
                        dbl    = dbl >> (DW_S - n);
                        result = {{EXT_W{1'b0}}, dbl[DATA_W-1:0]};
                    end else if (from_bsc) begin
                        dbl    = dbl >> n;
                        result = {{EXT_W{1'b0}}, dbl[DATA_W-1:0]};
                    end
                end
                default: begin
                    if (go_left) begin
                        rdbl    = rdbl >> (RW_S - n);
                        result  = {{EXT_W{1'b0}}, rdbl[DATA_W-1:0]};
                        tst_out = rdbl[DATA_W];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dsp_barrel_shifter.sv
module dsp_barrel_shifter
    import dbs_pkg::*;
#(
    parameter int ACC_W  = DBS_ACC_W,
    parameter int DATA_W = DBS_DATA_W,
    parameter int AMT_W  = DBS_AMT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bsc_we,
    input  logic [AMT_W-1:0]  bsc_wdata,
    input  logic              psc_we,
    input  logic [AMT_W-1:0]  psc_wdata,
    input  logic [1:0]        amt_src,
    input  logic [AMT_W-1:0]  imm_amt,
    input  logic [1:0]        op,
    input  logic              opnd_is_acc,
    input  logic [ACC_W-1:0]  opnd_acc,
    input  logic [DATA_W-1:0] opnd_word,
    input  logic              tst_in,
    output logic [ACC_W-1:0]  result,
    output logic              tst_out
);
    shift_ctrl_t      ctrl_d, ctrl_q;
    logic [AMT_W-1:0] bsc_q, psc_q;
    logic [AMT_W-1:0] mag;
    logic             go_left, is_zero, from_bsc;

    always_comb begin
        ctrl_d = ctrl_q;
        if (bsc_we) ctrl_d.bsc = bsc_wdata;
        if (psc_we) ctrl_d.psc = psc_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign bsc_q = ctrl_q.bsc;
    assign psc_q = ctrl_q.psc;

    dbs_amt_sel #(.AMT_W(AMT_W)) i_amt_sel (
        .amt_src  (amt_src),
        .imm_amt  (imm_amt),
        .bsc_amt  (bsc_q),
        .psc_amt  (psc_q),
        .mag      (mag),
        .go_left  (go_left),
        .is_zero  (is_zero),
        .from_bsc (from_bsc)
    );

    dbs_shift_core #(.ACC_W(ACC_W), .DATA_W(DATA_W), .AMT_W(AMT_W)) i_core (
        .op          (op),
        .mag         (mag),
        .go_left     (go_left),
        .is_zero     (is_zero),
        .from_bsc    (from_bsc),
        .opnd_is_acc (opnd_is_acc),
        .opnd_acc    (opnd_acc),
        .opnd_word   (opnd_word),
        .tst_in      (tst_in),
        .result      (result),
        .tst_out     (tst_out)
    );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int ACC_W  = 40,
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bsc_we,
    input logic [AMT_W-1:0]  bsc_wdata,
    input logic              psc_we,
    input logic [AMT_W-1:0]  psc_wdata,
    input logic [AMT_W-1:0]  bsc_q,
    input logic [AMT_W-1:0]  psc_q,
    input logic [1:0]        amt_src,
    input logic [AMT_W-1:0]  imm_amt,
    input logic [1:0]        op,
    input logic              opnd_is_acc,
    input logic [ACC_W-1:0]  opnd_acc,
    input logic              tst_in,
    input logic [ACC_W-1:0]  result,
    input logic              tst_out
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bsc_q == '0 && psc_q == '0));

    // R2
    bsc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsc_we |=> (bsc_q == $past(bsc_wdata)));

    // R2
    psc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_we |=> (psc_q == $past(psc_wdata)));

    // R2
    bsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bsc_we |=> $stable(bsc_q));

    // R4
    src_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_src == 2'b11 && opnd_is_acc) |-> (result == opnd_acc && tst_out == tst_in));

    // R5
    arith_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00 && amt_src == 2'b00 && imm_amt[AMT_W-1] && opnd_is_acc)
            |-> (result[ACC_W-1] == opnd_acc[ACC_W-1]));

    // R6
    logic_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && amt_src == 2'b00 && imm_amt != '0)
            |-> (result[ACC_W-1:DATA_W] == '0));

    // R7
    rot_tst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10) |-> (tst_out == tst_in));
endmodule

bind dsp_barrel_shifter dbs_checker #(.ACC_W(ACC_W), .DATA_W(DATA_W), .AMT_W(AMT_W)) i_dbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bsc_we      (bsc_we),
    .bsc_wdata   (bsc_wdata),
    .psc_we      (psc_we),
    .psc_wdata   (psc_wdata),
    .bsc_q       (bsc_q),
    .psc_q       (psc_q),
    .amt_src     (amt_src),
    .imm_amt     (imm_amt),
    .op          (op),
    .opnd_is_acc (opnd_is_acc),
    .opnd_acc    (opnd_acc),
    .tst_in      (tst_in),
    .result      (result),
    .tst_out     (tst_out)
);

// File: tb/test_dsp_barrel_shifter.sv
module test_dsp_barrel_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsc_we = 1'b0, psc_we = 1'b0;
    logic [5:0]  bsc_wdata = '0, psc_wdata = '0;
    logic [1:0]  amt_src = '0;
    logic [5:0]  imm_amt = '0;
    logic [1:0]  op = '0;
    logic        opnd_is_acc = 1'b0;
    logic [39:0] opnd_acc = '0;
    logic [31:0] opnd_word = '0;
    logic        tst_in = 1'b0;
    logic [39:0] result;
    logic        tst_out;

    int n_vec = 0;
    int n_bad = 0;
    int bsc_m = 0;
    int psc_m = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsp_barrel_shifter i_dsp_barrel_shifter (
        .clk(clk), .rst_n(rst_n),
        .bsc_we(bsc_we), .bsc_wdata(bsc_wdata),
        .psc_we(psc_we), .psc_wdata(psc_wdata),
        .amt_src(amt_src), .imm_amt(imm_amt), .op(op),
        .opnd_is_acc(opnd_is_acc), .opnd_acc(opnd_acc), .opnd_word(opnd_word),
        .tst_in(tst_in), .result(result), .tst_out(tst_out)
    );

    // Reference: one bit per step, from the requirement text.
    function automatic logic [40:0] model(int o, bit via_bsc, int amt, logic [39:0] e, logic t);
        logic [31:0] v;
        int k;
        k = (amt < 0) ? -amt : amt;
        v = e[31:0];
        if (amt == 0) return {t, e};
        case (o)
            0: begin
                for (int i = 0; i < k; i++) begin
                    if (amt > 0) begin t = e[39]; e = {e[38:0], 1'b0}; end
                    else         begin t = e[0];  e = {e[39], e[39:1]}; end
                end
                return {t, e};
            end
            1: begin
                for (int i = 0; i < k; i++) begin
                    if (amt > 0) begin t = v[31]; v = {v[30:0], 1'b0}; end
                    else         begin t = v[0];  v = {1'b0, v[31:1]}; end
                end
                return {t, 8'h00, v};
            end
            2: begin
                if (amt < 0 && !via_bsc) return {t, e};
                for (int i = 0; i < k; i++) begin
                    if (amt > 0) v = {v[30:0], v[31]};
                    else         v = {v[0], v[31:1]};
                end
                return {t, 8'h00, v};
            end
            default: begin
                logic nt;
                if (amt < 0) return {t, e};
                for (int i = 0; i < k; i++) begin
                    nt = v[31];
                    v  = {v[30:0], t};
                    t  = nt;
                end
                return {t, 8'h00, v};
            end
        endcase
    endfunction

    function automatic logic [39:0] widen(int o, bit acc, logic [39:0] a, logic [31:0] w);
        if (acc) return a;
        if (o == 0) return {{8{w[31]}}, w};
        return {8'h00, w};
    endfunction

    function automatic string tag_of(int o, int amt, int src);
        if (amt == 0 || src == 3) return "R4";
        case (o)
            0: return "R5";
            1: return "R6";
            2: return (amt < 0) ? "R8" : "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(string tag, int amt, int src);
        logic [40:0] exp;
        int o;
        o   = int'(op);
        exp = model(o, src == 1, amt, widen(o, opnd_is_acc, opnd_acc, opnd_word), tst_in);
        n_vec++;
        if ({tst_out, result} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d amt=%0d src=%0d acc=%0d: got tst=%0b res=%h, exp tst=%0b res=%h",
                     tag, o, amt, src, opnd_is_acc, tst_out, result, exp[40], exp[39:0]);
        end
    endtask

    // Drive at the falling edge, check 1 ns later.
    task automatic apply(int o, int src, int imm, bit acc, logic [39:0] a, logic [31:0] w, logic t, string tag);
        int amt;
        @(negedge clk);
        op = 2'(o); amt_src = 2'(src); imm_amt = 6'(imm);
        opnd_is_acc = acc; opnd_acc = a; opnd_word = w; tst_in = t;
        #1;
        amt = (src == 0) ? imm : (src == 1) ? bsc_m : (src == 2) ? psc_m : 0;
        compare(tag, amt, src);
    endtask

    task automatic wr_reg(bit is_bsc, int val);
        @(negedge clk);
        if (is_bsc) begin bsc_we = 1'b1; bsc_wdata = 6'(val); end
        else        begin psc_we = 1'b1; psc_wdata = 6'(val); end
        @(negedge clk);
        bsc_we = 1'b0; psc_we = 1'b0;
        if (is_bsc) bsc_m = val; else psc_m = val;
    endtask

    logic [39:0] acc_pat [4];
    logic [31:0] wrd_pat [4];

    initial begin
        acc_pat[0] = 40'hA5_8000_0001; acc_pat[1] = 40'h7F_FFFF_FFFE;
        acc_pat[2] = 40'h00_C3A5_5A3C; acc_pat[3] = 40'hFF_0000_FFFF;
        wrd_pat[0] = 32'h8000_0001;    wrd_pat[1] = 32'h7FFF_FFFE;
        wrd_pat[2] = 32'hC3A5_5A3C;    wrd_pat[3] = 32'h0000_FFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: both registers read as zero after reset
        for (int o = 0; o < 4; o++) begin
            apply(o, 1, 0, 1'b1, acc_pat[0], 32'h0, 1'b1, "R1");
            apply(o, 2, 0, 1'b0, 40'h0, wrd_pat[0], 1'b0, "R1");
        end

        // R3 R4 R5 R6 R7 R8 R9 R10: immediate sweep over every signed amount
        for (int o = 0; o < 4; o++)
            for (int amt = -32; amt < 32; amt++)
                for (int p = 0; p < 4; p++)
                    for (int acc = 0; acc < 2; acc++)
                        for (int t = 0; t < 2; t++)
                            apply(o, 0, amt, acc[0], acc_pat[p], wrd_pat[p], t[0], tag_of(o, amt, 0));

        // R3: source 11 means amount zero, even with a nonzero immediate
        for (int o = 0; o < 4; o++)
            apply(o, 3, 5, 1'b1, acc_pat[2], 32'h0, 1'b1, "R3");

        // R8 R2: every barrel-shift register value, all ops
        for (int amt = -32; amt < 32; amt++) begin
            wr_reg(1'b1, amt);
            for (int o = 0; o < 4; o++)
                apply(o, 1, 0, 1'b0, 40'h0, wrd_pat[2], 1'b1, tag_of(o, amt, 1));
        end

        // R8 R2: product-shift register drives a right rotate -> no effect
        for (int amt = -32; amt < 32; amt += 7) begin
            wr_reg(1'b0, amt);
            for (int o = 0; o < 4; o++)
                apply(o, 2, 0, 1'b1, acc_pat[3], 32'h0, 1'b0, tag_of(o, amt, 2));
        end

        // R2: writing one register leaves the other untouched
        wr_reg(1'b1, 3);
        wr_reg(1'b0, -4);
        wr_reg(1'b1, 9);
        apply(0, 2, 0, 1'b1, acc_pat[1], 32'h0, 1'b0, "R2");
        apply(0, 1, 0, 1'b1, acc_pat[1], 32'h0, 1'b0, "R2");

        // R2: write and use in the same cycle -> old value until the edge
        apply(1, 1, 0, 1'b0, 40'h0, wrd_pat[2], 1'b0, "R2");
        bsc_we = 1'b1; bsc_wdata = 6'(-5);
        #1; compare("R2", bsc_m, 1);
        @(posedge clk); #1;
        bsc_we = 1'b0; bsc_m = -5;
        compare("R2", bsc_m, 1);
        @(negedge clk);
        op = 2'b00; amt_src = 2'b10;
        psc_we = 1'b1; psc_wdata = 6'(12);
        #1; compare("R2", psc_m, 2);
        @(posedge clk); #1;
        psc_we = 1'b0; psc_m = 12;
        compare("R2", psc_m, 2);

        // R1: reset again clears both registers
        @(negedge clk); rst_n = 1'b0; bsc_m = 0; psc_m = 0;
        @(negedge clk); rst_n = 1'b1;
        apply(0, 1, 0, 1'b1, acc_pat[2], 32'h0, 1'b1, "R1");
        apply(3, 2, 0, 1'b1, acc_pat[2], 32'h0, 1'b1, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule